// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable total ratio of P*N + A. It does not use one wide loadable counter. Instead, a small prescaler divides the input by either P or P+1. Two slower counters then steer the prescaler: a swallow counter holding A and a main counter holding N. While the swallow count is nonzero, the prescaler stretches each of its periods by one input clock. Once the swallow count is exhausted, the prescaler runs at the base modulus until the main count expires. At that point the block emits a single-clock pulse and reloads.

A one-bit mode input picks the modulus pair. With the default parameter this is 128/129 or 64/65. A is 7 bits wide (0..127) and N is 11 bits wide (16..2047), and a valid setting requires A < N. The settings are captured only at a cycle boundary or during reset, so software can rewrite them at any time without corrupting the division in progress. The prescaler is modelled as a synchronous counter clocked by the input clock.

Top module: `dms_divider`

## Requirements
- R1: `half_mode` = 0 selects the modulus pair 128/129 (P = 128) and `half_mode` = 1 selects 64/65 (P = 64), for the default `LOG2_PLO` = 6. In general P = 2^(LOG2_PLO+1) when the input is 0 and P = 2^LOG2_PLO when it is 1.
- R2: Consecutive `div_pulse` assertions are exactly P*N + A clocks apart. Each pulse is high for exactly one clock, and that clock is the last clock of the division cycle.
- R3: `mod_ext` is high for the first A*(P+1) clocks of each division cycle and low for the remaining (N-A)*P clocks. With A = 0 it never rises.
- R4: The mode, A and N inputs are sampled only at the clock edge that ends a pulse clock, or at a reset edge. Changing them in the middle of a cycle has no effect on the running cycle.
- R5: `rst` is synchronous and active high. While it is high, `div_pulse` stays low and the inputs are captured continuously. The first pulse after release falls on clock number P*N + A, counting the first clock after the last reset edge as clock 1.
- R6: The corner settings A = 0, A = N-1, N = 16 and N = 2047 divide correctly in both modulus modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| half_mode | input | 1 | Modulus pair select: 0 for 2P_LO/2P_LO+1, 1 for P_LO/P_LO+1 |
| swallow_val | input | 7 | Swallow count A (0..127, must be below N) |
| main_val | input | 11 | Main count N (16..2047) |
| div_pulse | output | 1 | One-clock pulse on the last clock of each division cycle |
| mod_ext | output | 1 | High while the prescaler runs at modulus P+1 |

## Verification
The bench targets four situations. The first is A = 0, where a design that loads P+1 anyway would add N clocks to every period. The second is A = N-1, where an off-by-one in the switch point would make the last extended period run at the base modulus. The third is the N limits of 16 and 2047, where a main counter that expires one tick early or late shifts the period by a whole P. The fourth is a mid-cycle rewrite of all inputs, which would show up as a first period of the wrong length if the settings leaked in before the boundary. A second, smaller-prescaler instance runs N = 2047 in both modes, so the full main-counter range is covered within the run time. A behavioural phase counter checks the pulse and the modulus control on every clock.

// File: rtl/dms_pkg.sv
package dms_pkg;
    localparam int SWL_W  = 7;
    localparam int MAIN_W = 11;

    typedef struct packed {
        logic              half;
        logic [SWL_W-1:0]  swl;
        logic [MAIN_W-1:0] main;
    } dms_cfg_t;
endpackage

// File: rtl/dms_prescaler.sv
module dms_prescaler #(
    parameter int LOG2_PLO = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic half_nxt,
    input  logic ext_nxt,
    output logic tick
);
    localparam int PC_W = LOG2_PLO + 2;
    localparam logic [PC_W-1:0] P_LO = PC_W'(1) << LOG2_PLO;
    localparam logic [PC_W-1:0] P_HI = PC_W'(1) << (LOG2_PLO + 1);

    typedef struct packed {
        logic [PC_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PC_W-1:0] base;

    assign tick = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        base = half_nxt ? P_LO : P_HI;
        if (rst || tick) begin
            st_d.cnt = ext_nxt ? base : base - PC_W'(1);
        end else begin
            st_d.cnt = st_q.cnt - PC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R1: the period counter never exceeds the larger modulus
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= P_HI);
endmodule

// File: rtl/dms_swallow_ctl.sv
module dms_swallow_ctl
    import dms_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  dms_cfg_t cfg_nxt,
    output logic     ext_nxt,
    output logic     ext_now,
    output logic     cyc_end
);
    typedef struct packed {
        logic [SWL_W-1:0]  swl;
        logic [MAIN_W-1:0] main;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    assign cyc_end = tick && (st_q.main == MAIN_W'(1));
    assign ext_now = (st_q.swl != '0);
    assign ext_nxt = (st_d.swl != '0);

    always_comb begin
        st_d = st_q;
        if (rst || cyc_end) begin
            st_d.swl  = cfg_nxt.swl;
            st_d.main = cfg_nxt.main;
        end else if (tick) begin
            st_d.main = st_q.main - MAIN_W'(1);
            if (st_q.swl != '0) begin
                st_d.swl = st_q.swl - SWL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R2: the counters move only on a prescaler period boundary
    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(st_q.main) && $stable(st_q.swl)));
    // R3: the extended modulus ends only on a prescaler period boundary
    p_ext_drop_at_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(ext_now)) |-> $past(tick));
    // R6: with valid settings the main count never underflows
    p_main_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        st_q.main != '0);
endmodule

// File: rtl/dms_divider.sv
module dms_divider
    import dms_pkg::*;
#(
    parameter int LOG2_PLO = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_mode,
    input  logic [SWL_W-1:0]  swallow_val,
    input  logic [MAIN_W-1:0] main_val,
    output logic              div_pulse,
    output logic              mod_ext
);
    typedef struct packed {
        dms_cfg_t cfg;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    tick;
    logic    ext_nxt;
    logic    ext_now;
    logic    cyc_end;

    always_comb begin
        st_d = st_q;
        if (rst || cyc_end) begin
            st_d.cfg.half = half_mode;
            st_d.cfg.swl  = swallow_val;
            st_d.cfg.main = main_val;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    dms_prescaler #(.LOG2_PLO(LOG2_PLO)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .half_nxt (st_d.cfg.half),
        .ext_nxt  (ext_nxt),
        .tick     (tick)
    );

    dms_swallow_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cfg_nxt (st_d.cfg),
        .ext_nxt (ext_nxt),
        .ext_now (ext_now),
        .cyc_end (cyc_end)
    );

    assign div_pulse = cyc_end;
    assign mod_ext   = ext_now;

    // R2: a pulse lasts exactly one clock
    p_one_clock_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);
    // R4: the captured settings hold for the whole cycle
    p_cfg_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !div_pulse |=> $stable(st_q.cfg));
endmodule

// File: tb/tb_dms_divider.sv
module tb_dms_divider;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        half_mode = 1'b0;
    logic [6:0]  swallow_val = 7'd0;
    logic [10:0] main_val = 11'd16;
    logic        pulse_a, mod_a, pulse_b, mod_b;

    int n_chk = 0;
    int n_bad = 0;
    int ph[2];
    int rat[2];
    int ext[2];
    bit live = 1'b0;

    always #5 clk = ~clk;

    dms_divider #(.LOG2_PLO(6)) dut (
        .clk(clk), .rst(rst), .half_mode(half_mode), .swallow_val(swallow_val),
        .main_val(main_val), .div_pulse(pulse_a), .mod_ext(mod_a));

    dms_divider #(.LOG2_PLO(2)) dut_s (
        .clk(clk), .rst(rst), .half_mode(half_mode), .swallow_val(swallow_val),
        .main_val(main_val), .div_pulse(pulse_b), .mod_ext(mod_b));

    function automatic int pval(int lg, bit h);
        return h ? (1 << lg) : (2 << lg);
    endfunction

    function automatic int lg_of(int which);
        return (which == 0) ? 6 : 2;
    endfunction

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // behavioural phase model: the phase within the cycle, the cycle length, the extended span
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            int p;
            p = pval(lg_of(i), half_mode);
            if (rst || ph[i] == rat[i]) begin
                rat[i] = p * int'(main_val) + int'(swallow_val);
                ext[i] = (p + 1) * int'(swallow_val);
                ph[i]  = 1;
            end else begin
                ph[i]++;
            end
        end
        if (rst) live = 1'b1;
    end

    always @(negedge clk) begin
        if (live) begin
            chk($sformatf("R2 pulse dut0 phase %0d", ph[0]), int'(pulse_a), int'(ph[0] == rat[0]));
            chk($sformatf("R3 mod dut0 phase %0d", ph[0]), int'(mod_a), int'(ph[0] <= ext[0]));
            chk($sformatf("R2 pulse dut1 phase %0d", ph[1]), int'(pulse_b), int'(ph[1] == rat[1]));
            chk($sformatf("R3 mod dut1 phase %0d", ph[1]), int'(mod_b), int'(ph[1] <= ext[1]));
        end
    end

    function automatic logic pl(int which);
        return (which == 0) ? pulse_a : pulse_b;
    endfunction

    task automatic run(string tag, int which, bit h, int n, int a,
                       bit mid, bit h2, int n2, int a2);
        int k;
        int e1;
        int e2;
        e1 = pval(lg_of(which), h) * n + a;
        e2 = mid ? pval(lg_of(which), h2) * n2 + a2 : e1;
        @(negedge clk);
        rst = 1'b1;
        half_mode = h;
        main_val = 11'(n);
        swallow_val = 7'(a);
        repeat (3) @(negedge clk);
        // R5: reset state
        chk({"R5 pulse low in reset ", tag}, int'(pl(which)), 0);
        chk({"R3 mod in reset ", tag}, int'((which == 0) ? mod_a : mod_b), int'(a != 0));
        rst = 1'b0;
        k = 1;
        while (!pl(which)) begin
            @(negedge clk);
            k++;
            if (mid && k == 100) begin
                half_mode = h2;
                main_val = 11'(n2);
                swallow_val = 7'(a2);
            end
        end
        chk({"R5 R4 R1 first period ", tag}, k, e1);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!pl(which));
        chk({"R2 R6 second period ", tag}, k, e2);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R6 corners: N=16 with A=0 and A=N-1, both modes
        run("R6 m0 N16 A0", 0, 1'b0, 16, 0, 1'b0, 1'b0, 0, 0);
        run("R6 m0 N16 A15", 0, 1'b0, 16, 15, 1'b0, 1'b0, 0, 0);
        run("R6 m1 N16 A0", 0, 1'b1, 16, 0, 1'b0, 1'b0, 0, 0);
        run("R6 m1 N16 A15", 0, 1'b1, 16, 15, 1'b0, 1'b0, 0, 0);
        run("R3 m1 N40 A39", 0, 1'b1, 40, 39, 1'b0, 1'b0, 0, 0);
        // R4: settings rewritten mid-cycle apply only from the next cycle
        run("R4 mid rewrite", 0, 1'b0, 20, 7, 1'b1, 1'b1, 18, 3);
        // R6: N=2047 on the small-prescaler instance, both modes
        run("R6 m0 N2047 A0", 1, 1'b0, 2047, 0, 1'b0, 1'b0, 0, 0);
        run("R6 m0 N2047 A127", 1, 1'b0, 2047, 127, 1'b0, 1'b0, 0, 0);
        run("R6 m1 N2047 A0", 1, 1'b1, 2047, 0, 1'b0, 1'b0, 0, 0);
        run("R6 m1 N2047 A127", 1, 1'b1, 2047, 127, 1'b0, 1'b0, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule